// File: doc/BRIEF.md
# Checkpoint and Rollback Group Coordinator

This block decides which processors must take part when one processor starts a checkpoint or a rollback, and then runs the agreement round with them. Each processor keeps two dependence bitmaps. One lists the processors whose data it consumed, called its producers. The other lists the processors that consumed its data, called its consumers. When an operation starts, the coordinator copies the relevant matrix. It then grows a member set outward from the initiator, one dependence level per clock, until no new processor is reached.

A checkpoint follows producer links and a rollback follows consumer links. The finished set is asked to join with a one-cycle request strobe. Each member answers accept or decline. A decliner is dropped and receives an acknowledge pulse. Once every member has answered, the remaining group is sent a commit strobe. If answers are still missing after a programmable number of waiting cycles, the group is sent an abort strobe instead. The actual state saving, cache invalidation and log restore happen outside the block and are triggered by these strobes.

Top module: `isc_coordinator`

## Requirements
- R1: For a checkpoint (`init_rollback`=0) the group is every processor reachable from the initiator through producer links, where `dep_prod[i*N+j]`=1 means j is a producer of i. The group always includes the initiator. `req_strobe` pulses for one cycle with the group minus the initiator.
- R2: For a rollback (`init_rollback`=1) the group is built the same way from `dep_cons`, where `dep_cons[i*N+j]`=1 means j consumed data from i. Producer links play no part.
- R3: Both matrices are copied in the cycle the initiate request is taken. Later changes to `dep_prod` and `dep_cons` do not alter the group of the running operation.
- R4: Responses count only from the cycle after `req_strobe` onward, and only from processors that were requested and have not yet answered. Responses from any other processor are ignored. If a processor asserts accept and decline together, decline wins.
- R5: A member that declines is removed from `member_mask`. `ack_strobe` pulses its bit in the next cycle.
- R6: When every requested member has answered, `commit_strobe` pulses once with the final group, together with `done`=1 and `done_ok`=1. No processor outside the closure is ever included.
- R7: If some member has not answered after `timeout_cycles` waiting cycles, `abort_strobe` pulses with the current group, together with `done`=1 and `done_ok`=0. The abort strobe therefore appears `timeout_cycles`+1 cycles after the request strobe.
- R8: While an operation is in progress, `busy`=1. An initiate request in that time raises `init_reject` in the same cycle and has no effect on the running operation.
- R9: After reset, `busy`, `done`, `init_reject` and every strobe are 0, and `member_mask` is 0.
- R10: `op_rollback` shows the kind of the operation last accepted and holds it after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_valid | input | 1 | Start an operation |
| init_id | input | $clog2(N_PROC) | Initiating processor |
| init_rollback | input | 1 | 1 = rollback, 0 = checkpoint |
| timeout_cycles | input | TO_W | Waiting-cycle limit for responses |
| dep_prod | input | N_PROC*N_PROC | Producer bitmaps, row i at bits i*N |
| dep_cons | input | N_PROC*N_PROC | Consumer bitmaps, row i at bits i*N |
| resp_accept | input | N_PROC | Per-processor accept |
| resp_decline | input | N_PROC | Per-processor decline |
| busy | output | 1 | Operation in progress |
| init_reject | output | 1 | Initiate refused while busy |
| op_rollback | output | 1 | Kind of the last accepted operation |
| req_strobe | output | N_PROC | Join request to members |
| ack_strobe | output | N_PROC | Acknowledge to decliners |
| commit_strobe | output | N_PROC | Commit to final group |
| abort_strobe | output | N_PROC | Abort to current group |
| done | output | 1 | Operation finished |
| done_ok | output | 1 | Finished by commit |
| member_mask | output | N_PROC | Current or last group |

## Verification
On every cycle, the assertions check several timing and consistency rules. Initiate requests made while busy are always refused. Request strobes and done pulses last a single cycle. An abort only follows an expired timer. A commit always carries a successful done. Acknowledged decliners are absent from the group, and the group never grows once requests have gone out. The group content itself can only be judged by the bench scenarios. Those scenarios cover a sweep of initiators, both operation kinds and many dependence matrices against a closure computed in the bench. They also cover the matrix snapshot, ignored and conflicting responses, and the exact cycle at which a timeout aborts.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_REQ,
    ST_WAIT,
    ST_COMMIT,
    ST_ABORT
  } isc_state_e;
endpackage

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int N_PROC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_valid,
  input  logic              init_rollback,
  input  logic [N_PROC-1:0] id_oh,
  input  logic              closure_conv,
  input  logic              all_resp,
  input  logic              timed_out,
  output isc_state_e        st,
  output logic              load,
  output logic [N_PROC-1:0] init_oh,
  output logic              op_rollback
);
  isc_state_e        st_q, st_d;
  logic [N_PROC-1:0] oh_q;
  logic              op_q;

  assign load = (st_q == ST_IDLE) && init_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (init_valid) st_d = ST_CLOSE;
      ST_CLOSE:  if (closure_conv) st_d = ST_REQ;
      ST_REQ:    st_d = ST_WAIT;
      ST_WAIT: begin
        if (all_resp)       st_d = ST_COMMIT;
        else if (timed_out) st_d = ST_ABORT;
      end
      ST_COMMIT: st_d = ST_IDLE;
      ST_ABORT:  st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oh_q <= '0;
      op_q <= 1'b0;
    end else if (load) begin
      oh_q <= id_oh;
      op_q <= init_rollback;
    end
  end

  assign st          = st_q;
  assign init_oh     = oh_q;
  assign op_rollback = op_q;
endmodule

// File: rtl/isc_closure.sv
module isc_closure #(
  parameter int N_PROC = 4,
  localparam int MW    = N_PROC * N_PROC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              use_cons,
  input  logic [N_PROC-1:0] seed_oh,
  input  logic [MW-1:0]     dep_prod,
  input  logic [MW-1:0]     dep_cons,
  output logic [N_PROC-1:0] mask,
  output logic              conv
);
  logic [N_PROC-1:0] rows_q [N_PROC];
  logic [N_PROC-1:0] mask_q, mask_d;
  logic [N_PROC-1:0] front_q, front_d;
  logic [N_PROC-1:0] reach;

  for (genvar r = 0; r < N_PROC; r++) begin : g_row
    logic [N_PROC-1:0] src;
    assign src = use_cons ? dep_cons[r*N_PROC +: N_PROC]
                          : dep_prod[r*N_PROC +: N_PROC];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rows_q[r] <= '0;
      else if (load) rows_q[r] <= src;
    end
  end

  always_comb begin
    reach = '0;
    for (int i = 0; i < N_PROC; i++) begin
      if (front_q[i]) reach = reach | rows_q[i];
    end
  end

  always_comb begin
    mask_d  = mask_q;
    front_d = front_q;
    if (load) begin
      mask_d  = seed_oh;
      front_d = seed_oh;
    end else if (step) begin
      mask_d  = mask_q | reach;
      front_d = reach & ~mask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      front_q <= '0;
    end else begin
      mask_q  <= mask_d;
      front_q <= front_d;
    end
  end

  assign mask = mask_q;
  assign conv = ((reach & ~mask_q) == '0);
endmodule

// File: rtl/isc_handshake.sv
module isc_handshake #(
  parameter int N_PROC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  input  logic              active,
  input  logic [N_PROC-1:0] closure_mask,
  input  logic [N_PROC-1:0] init_oh,
  input  logic [N_PROC-1:0] resp_accept,
  input  logic [N_PROC-1:0] resp_decline,
  output logic [N_PROC-1:0] members,
  output logic [N_PROC-1:0] ack,
  output logic              all_resp
);
  logic [N_PROC-1:0] mem_q, mem_d;
  logic [N_PROC-1:0] pend_q, pend_d;
  logic [N_PROC-1:0] ack_q, ack_d;
  logic [N_PROC-1:0] seen, dec_eff;

  assign seen    = (resp_accept | resp_decline) & pend_q;
  assign dec_eff = resp_decline & pend_q;

  always_comb begin
    mem_d  = mem_q;
    pend_d = pend_q;
    ack_d  = '0;
    if (clear) begin
      mem_d  = '0;
      pend_d = '0;
    end else if (start) begin
      mem_d  = closure_mask;
      pend_d = closure_mask & ~init_oh;
    end else if (active) begin
      pend_d = pend_q & ~seen;
      mem_d  = mem_q & ~dec_eff;
      ack_d  = dec_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= '0;
      pend_q <= '0;
      ack_q  <= '0;
    end else begin
      mem_q  <= mem_d;
      pend_q <= pend_d;
      ack_q  <= ack_d;
    end
  end

  assign members  = mem_q;
  assign ack      = ack_q;
  assign all_resp = ((pend_q & ~seen) == '0);
endmodule

// File: rtl/isc_timer.sv
module isc_timer #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TO_W-1:0] limit,
  input  logic            clear,
  input  logic            run,
  output logic            hit
);
  logic [TO_W-1:0] lim_q;
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic [TO_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + {{TO_W{1'b0}}, 1'b1};
  assign hit    = (cnt_nx >= {1'b0, lim_q});

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (run) cnt_d = cnt_nx[TO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lim_q <= '0;
    else if (load) lim_q <= limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/isc_coordinator.sv
module isc_coordinator
  import isc_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int TO_W   = 8,
  localparam int IDW   = (N_PROC > 1) ? $clog2(N_PROC) : 1,
  localparam int MW    = N_PROC * N_PROC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_valid,
  input  logic [IDW-1:0]    init_id,
  input  logic              init_rollback,
  input  logic [TO_W-1:0]   timeout_cycles,
  input  logic [MW-1:0]     dep_prod,
  input  logic [MW-1:0]     dep_cons,
  input  logic [N_PROC-1:0] resp_accept,
  input  logic [N_PROC-1:0] resp_decline,
  output logic              busy,
  output logic              init_reject,
  output logic              op_rollback,
  output logic [N_PROC-1:0] req_strobe,
  output logic [N_PROC-1:0] ack_strobe,
  output logic [N_PROC-1:0] commit_strobe,
  output logic [N_PROC-1:0] abort_strobe,
  output logic              done,
  output logic              done_ok,
  output logic [N_PROC-1:0] member_mask
);
  isc_state_e        st;
  logic              load;
  logic [N_PROC-1:0] id_oh;
  logic [N_PROC-1:0] init_oh;
  logic [N_PROC-1:0] cl_mask;
  logic              cl_conv;
  logic              all_resp;
  logic              to_hit;
  logic [N_PROC-1:0] members;

  assign id_oh = {{(N_PROC-1){1'b0}}, 1'b1} << init_id;

  isc_ctrl #(.N_PROC(N_PROC)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_valid   (init_valid),
    .init_rollback(init_rollback),
    .id_oh        (id_oh),
    .closure_conv (cl_conv),
    .all_resp     (all_resp),
    .timed_out    (to_hit),
    .st           (st),
    .load         (load),
    .init_oh      (init_oh),
    .op_rollback  (op_rollback)
  );

  isc_closure #(.N_PROC(N_PROC)) u_closure (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (st == ST_CLOSE),
    .use_cons(init_rollback),
    .seed_oh (id_oh),
    .dep_prod(dep_prod),
    .dep_cons(dep_cons),
    .mask    (cl_mask),
    .conv    (cl_conv)
  );

  isc_handshake #(.N_PROC(N_PROC)) u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (load),
    .start       (st == ST_REQ),
    .active      (st == ST_WAIT),
    .closure_mask(cl_mask),
    .init_oh     (init_oh),
    .resp_accept (resp_accept),
    .resp_decline(resp_decline),
    .members     (members),
    .ack         (ack_strobe),
    .all_resp    (all_resp)
  );

  isc_timer #(.TO_W(TO_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .limit(timeout_cycles),
    .clear(st == ST_REQ),
    .run  (st == ST_WAIT),
    .hit  (to_hit)
  );

  assign busy          = (st != ST_IDLE);
  assign init_reject   = init_valid && busy;
  assign req_strobe    = (st == ST_REQ)    ? (cl_mask & ~init_oh) : '0;
  assign commit_strobe = (st == ST_COMMIT) ? members : '0;
  assign abort_strobe  = (st == ST_ABORT)  ? members : '0;
  assign done          = (st == ST_COMMIT) || (st == ST_ABORT);
  assign done_ok       = (st == ST_COMMIT);
  assign member_mask   = members;
endmodule

// File: rtl/isc_coordinator_chk.sv
module isc_coordinator_chk
  import isc_pkg::*;
#(
  parameter int N_PROC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_valid,
  input logic              busy,
  input logic              init_reject,
  input logic [N_PROC-1:0] req_strobe,
  input logic [N_PROC-1:0] ack_strobe,
  input logic [N_PROC-1:0] commit_strobe,
  input logic [N_PROC-1:0] abort_strobe,
  input logic [N_PROC-1:0] resp_decline,
  input logic              done,
  input logic              done_ok,
  input logic [N_PROC-1:0] member_mask,
  input isc_state_e        st,
  input logic              to_hit
);
  a_r8_reject_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (init_valid && busy) |-> init_reject);

  a_r8_reject_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    init_reject |-> busy);

  a_r1_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe != '0) |=> (req_strobe == '0));

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_commit_is_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_strobe != '0) |-> (done && done_ok));

  a_r7_abort_after_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_strobe != '0) |-> ($past(to_hit) && done && !done_ok));

  a_r5_ack_from_decline: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe != '0) |-> (($past(resp_decline) & ack_strobe) == ack_strobe));

  a_r5_ack_not_member: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe & member_mask) == '0);

  a_r6_group_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && ($past(st) != ST_REQ))
      |-> ((member_mask & ~$past(member_mask)) == '0));
endmodule

bind isc_coordinator isc_coordinator_chk #(.N_PROC(N_PROC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_valid   (init_valid),
  .busy         (busy),
  .init_reject  (init_reject),
  .req_strobe   (req_strobe),
  .ack_strobe   (ack_strobe),
  .commit_strobe(commit_strobe),
  .abort_strobe (abort_strobe),
  .resp_decline (resp_decline),
  .done         (done),
  .done_ok      (done_ok),
  .member_mask  (member_mask),
  .st           (st),
  .to_hit       (to_hit)
);

// File: tb/isc_coordinator_tb.sv
module isc_coordinator_tb;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int MW = N * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init_valid = 1'b0;
  logic [1:0]    init_id = '0;
  logic          init_rollback = 1'b0;
  logic [TW-1:0] timeout_cycles = 8'd20;
  logic [MW-1:0] dep_prod = '0;
  logic [MW-1:0] dep_cons = '0;
  logic [N-1:0]  resp_accept = '0;
  logic [N-1:0]  resp_decline = '0;
  logic          busy, init_reject, op_rollback, done, done_ok;
  logic [N-1:0]  req_strobe, ack_strobe, commit_strobe, abort_strobe, member_mask;

  int checks = 0;
  int fails  = 0;

  // Results of the last operation
  logic [N-1:0] o_req, o_ack, o_commit, o_abort;
  logic         o_ok, o_fin, o_rej;
  int           o_req_cyc, o_end_cyc;

  always #5 clk = ~clk;

  isc_coordinator #(.N_PROC(N), .TO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_id(init_id),
    .init_rollback(init_rollback), .timeout_cycles(timeout_cycles),
    .dep_prod(dep_prod), .dep_cons(dep_cons), .resp_accept(resp_accept),
    .resp_decline(resp_decline), .busy(busy), .init_reject(init_reject),
    .op_rollback(op_rollback), .req_strobe(req_strobe), .ack_strobe(ack_strobe),
    .commit_strobe(commit_strobe), .abort_strobe(abort_strobe), .done(done),
    .done_ok(done_ok), .member_mask(member_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] closure(input int id, input logic [MW-1:0] m);
    logic [N-1:0] g = N'(1) << id;
    for (int k = 0; k < N; k++)
      for (int i = 0; i < N; i++)
        if (g[i]) g = g | m[i*N +: N];
    return g;
  endfunction

  function automatic logic [MW-1:0] gen_mat(input int s, input int k);
    logic [31:0] x = 32'(s) * 32'd1103515245 + 32'(k) * 32'd40503 + 32'd97;
    x = x ^ (x >> 13);
    x = x ^ (x << 7);
    x = x ^ (x >> 11);
    return x[15:0] & x[31:16];
  endfunction

  // Start one operation, answer the request once, observe until done.
  task automatic run_op(input int id, input bit rb, input logic [N-1:0] acc,
                        input logic [N-1:0] dec, input bit change_mat,
                        input bit poke_busy);
    bit go = 0, clr = 0;
    o_req = '0; o_ack = '0; o_commit = '0; o_abort = '0;
    o_ok = 0; o_fin = 0; o_rej = 0; o_req_cyc = -1; o_end_cyc = -1;
    init_id = 2'(id); init_rollback = rb; init_valid = 1'b1;
    @(negedge clk);
    init_valid = 1'b0;
    if (change_mat) begin dep_prod = '1; dep_cons = '1; end
    if (poke_busy) begin
      init_id = 2'(id + 1); init_rollback = ~rb; init_valid = 1'b1;
      #1 o_rej = init_reject;
    end
    for (int c = 0; c < 300; c++) begin
      if (c == 1 && poke_busy) begin
        init_valid = 1'b0; init_id = 2'(id); init_rollback = rb;
      end
      if (clr) begin resp_accept = '0; resp_decline = '0; clr = 0; end
      if (go) begin resp_accept = acc; resp_decline = dec; go = 0; clr = 1; end
      o_ack = o_ack | ack_strobe;
      if (req_strobe != '0) begin o_req = req_strobe; o_req_cyc = c; go = 1; end
      if (done) begin
        o_commit = commit_strobe; o_abort = abort_strobe; o_ok = done_ok;
        o_end_cyc = c; o_fin = 1;
        break;
      end
      @(negedge clk);
    end
    init_valid = 1'b0; resp_accept = '0; resp_decline = '0;
    chk(o_fin, "R6 operation finished", 32'(o_fin), 1);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] g;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !done && !init_reject, "R9 flags after reset",
        {busy, done, init_reject}, 0);
    chk(req_strobe == 0 && commit_strobe == 0 && abort_strobe == 0 && ack_strobe == 0,
        "R9 strobes after reset", {req_strobe, commit_strobe, abort_strobe}, 0);
    chk(member_mask == 0, "R9 member mask after reset", member_mask, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2/R6/R10: sweep of matrices, initiators and both kinds, all accept
    for (int s = 0; s < 8; s++) begin
      dep_prod = gen_mat(s, 1);
      dep_cons = gen_mat(s, 2);
      for (int id = 0; id < N; id++) begin
        for (int rb = 0; rb < 2; rb++) begin
          g = closure(id, rb ? dep_cons : dep_prod);
          run_op(id, rb[0], '1, '0, 0, 0);
          chk(o_req == (g & ~(N'(1) << id)), rb ? "R2 request set" : "R1 request set",
              o_req, g & ~(N'(1) << id));
          chk(o_commit == g && o_ok && o_abort == 0, "R6 commit group", o_commit, g);
          chk(op_rollback == rb[0], "R10 op kind held", op_rollback, rb);
        end
      end
    end

    // R1: three-level producer chain 0->1->2->3
    dep_prod = '0; dep_cons = '0;
    dep_prod[0*N+1] = 1'b1; dep_prod[1*N+2] = 1'b1; dep_prod[2*N+3] = 1'b1;
    run_op(0, 0, '1, '0, 0, 0);
    chk(o_commit == 4'b1111, "R1 chain closure", o_commit, 4'b1111);
    // R2: rollback ignores producer links
    run_op(0, 1, '1, '0, 0, 0);
    chk(o_commit == 4'b0001 && o_req == 0, "R2 rollback uses consumer rows", o_commit, 4'b0001);
    // R2: consumer chain from 3
    dep_cons[3*N+2] = 1'b1; dep_cons[2*N+0] = 1'b1;
    run_op(3, 1, '1, '0, 0, 0);
    chk(o_commit == 4'b1101, "R2 consumer chain", o_commit, 4'b1101);

    // R3: matrix change after start has no effect
    dep_prod = '0; dep_cons = '0;
    dep_prod[0*N+1] = 1'b1; dep_prod[1*N+2] = 1'b1;
    run_op(0, 0, '1, '0, 1, 0);
    chk(o_commit == 4'b0111, "R3 snapshot held", o_commit, 4'b0111);
    dep_prod = '0; dep_prod[0*N+1] = 1'b1; dep_prod[1*N+2] = 1'b1;
    dep_cons = '0;

    // R4: responses from non-members and from the initiator are ignored
    run_op(0, 0, 4'b1110, 4'b1001, 0, 0);
    chk(o_commit == 4'b0111, "R4 ignored responses commit", o_commit, 4'b0111);
    chk(o_ack == 0, "R4 non-member decline not acknowledged", o_ack, 0);

    // R4/R5: accept and decline together, decline wins
    run_op(0, 0, 4'b0110, 4'b0100, 0, 0);
    chk(o_commit == 4'b0011, "R4 decline priority", o_commit, 4'b0011);
    chk(o_ack == 4'b0100, "R5 ack to decliner", o_ack, 4'b0100);
    chk(member_mask == 4'b0011, "R5 member mask after decline", member_mask, 4'b0011);

    // R7: timeout with one member silent
    timeout_cycles = 8'd5;
    run_op(0, 0, 4'b0010, '0, 0, 0);
    chk(o_abort == 4'b0111 && o_commit == 0 && !o_ok, "R7 abort group", o_abort, 4'b0111);
    chk(o_end_cyc - o_req_cyc == 6, "R7 abort timing 5", 32'(o_end_cyc - o_req_cyc), 6);
    timeout_cycles = 8'd3;
    run_op(1, 0, '0, '0, 0, 0);
    chk(o_abort == 4'b0110, "R7 abort group silent", o_abort, 4'b0110);
    chk(o_end_cyc - o_req_cyc == 4, "R7 abort timing 3", 32'(o_end_cyc - o_req_cyc), 4);
    timeout_cycles = 8'd20;

    // R8: initiate while busy is refused and does not disturb
    run_op(0, 0, '1, '0, 0, 1);
    chk(o_rej, "R8 reject while busy", 32'(o_rej), 1);
    chk(o_commit == 4'b0111 && op_rollback == 1'b0, "R8 running op undisturbed",
        {op_rollback, o_commit}, 4'b0111);
    chk(!busy, "R8 idle after completion", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule